// File: doc/BRIEF.md
# NAND Flash Device Interface Front-End

This block is the device side of an 8-bit multiplexed NAND-style flash bus. The host drives one shared byte port together with strobes and latch-enable levels. When write-enable rises, those levels decide how the byte is taken. A high command-latch level stores it as a command. A high address-latch level stores it as an address byte. With both levels low it becomes write data. Read data leaves the device on falling read-enable edges, and an internal column counter advances with each byte.

A small register array stands in for the flash cells. There is one page buffer, and the array holds `ROWS` pages of `PAGE` bytes each. Three fixed sequences are supported:

- **Read:** `00h`, column, row, `30h`.
- **Program:** `80h`, column, row, then data bytes, then `10h`.
- **Erase:** `60h`, row, `D0h`.

Each confirm command starts a busy period with a fixed cycle count, and the array transfer happens when that period ends. Ready/busy is open-drain, so it is modelled as a pull-low request. The array resets to all `FFh`.

Top module: `nand_front`

## Requirements
- R1: A byte is taken as a command only on a write-enable rising edge while command-latch is high and address-latch is low. The same byte sent with both latches low is not treated as a command.
- R2: After `00h` or `80h`, the first address byte sets the column (its low log2(PAGE) bits) and the second sets the row (its low log2(ROWS) bits). After `60h`, the single address byte sets the row. A new command resets the address byte count.
- R3: In a program sequence, data bytes that follow both address bytes are written into the page buffer at the column counter, and the counter steps by one per byte.
- R4: In the data-output state, each falling read-enable edge loads `io_o` with the page buffer byte at the column counter, and the counter steps by one.
- R5: `busy_pull` is 1 for exactly `T_READ`, `T_PROG` or `T_ERASE` cycles after a valid read, program or erase confirm. It can rise only as a result of a command latch.
- R6: A high `ce_n` during a busy period is ignored. `stby` stays 0 and the operation completes normally.
- R7: When `ce_n` is high and the device is not busy, `stby` is 1 and `io_oe` is 0.
- R8: With `wp_n` low, program and erase confirms leave the array unchanged and never raise `busy_pull`.
- R9: `io_oe` is 1 only while `ce_n` is low, `re_n` is low and the device is in the data-output state.
- R10: `80h` fills the page buffer with `FFh`, so unwritten bytes of a programmed page read back as `FFh`. An erase sets every byte of the addressed row to `FFh`.
- R11: Write-enable edges are ignored while `ce_n` is high or while the device is busy.
- R12: After reset, `busy_pull` is 0 and `io_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch level |
| ale | input | 1 | Address latch level |
| we_n | input | 1 | Write strobe, latches on rising edge |
| re_n | input | 1 | Read strobe, output on falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_i | input | 8 | Shared byte port, inbound |
| io_o | output | 8 | Shared byte port, outbound |
| io_oe | output | 1 | Drive enable for io_o |
| busy_pull | output | 1 | Pull ready/busy line low |
| stby | output | 1 | Low-power standby indication |

## Verification
Most faults surface within one strobe. A wrong address byte order or a column counter that does not step shows up as a wrong value on the very next read byte. A bad mode register shows up either as `io_oe` going high outside data output or as a confirm that raises no busy. A timer fault shows up as a busy width that differs from the parameter by the end of that operation. A fault in write-protect or chip-enable gating changes array content, which shows up only at the next read-back of the affected row.

// File: rtl/nand_front.sv
module nand_front #(
  parameter int PAGE    = 16,
  parameter int ROWS    = 4,
  parameter int T_READ  = 8,
  parameter int T_PROG  = 20,
  parameter int T_ERASE = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       io_oe,
  output logic       busy_pull,
  output logic       stby
);
  localparam int CW   = $clog2(PAGE);
  localparam int RW   = $clog2(ROWS);
  localparam int TMX1 = (T_READ > T_PROG) ? T_READ : T_PROG;
  localparam int TMAX = (TMX1 > T_ERASE) ? TMX1 : T_ERASE;
  localparam int TW   = $clog2(TMAX + 1);

  localparam logic [7:0] C_RD = 8'h00, C_RDGO = 8'h30;
  localparam logic [7:0] C_PG = 8'h80, C_PGGO = 8'h10;
  localparam logic [7:0] C_ER = 8'h60, C_ERGO = 8'hD0;

  typedef enum logic [2:0] {M_IDLE, M_RDA, M_OUT, M_PGA, M_ERA} mode_t;
  typedef enum logic [1:0] {OP_RD, OP_PG, OP_ER} op_t;

  mode_t          mode;
  op_t            op;
  logic           we_q, re_q;
  logic [1:0]     nab;
  logic [CW-1:0]  col;
  logic [RW-1:0]  row;
  logic [TW-1:0]  timer;
  logic [7:0]     dout;
  logic [7:0]     page [PAGE];
  logic [7:0]     mem  [ROWS][PAGE];

  logic busy, done, act, wstb, cmd_stb, adr_stb, dat_stb, rstb;
  assign busy    = timer != '0;
  assign done    = timer == TW'(1);
  assign act     = !ce_n && !busy;
  assign wstb    = act && we_n && !we_q;
  assign cmd_stb = wstb && cle && !ale;
  assign adr_stb = wstb && ale && !cle;
  assign dat_stb = wstb && !cle && !ale;
  assign rstb    = act && !re_n && re_q && mode == M_OUT;

  assign io_o      = dout;
  assign io_oe     = !ce_n && !re_n && mode == M_OUT && !busy;
  assign busy_pull = busy;
  assign stby      = ce_n && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1; re_q <= 1'b1;
      mode <= M_IDLE; op <= OP_RD;
      nab <= '0; col <= '0; row <= '0; timer <= '0; dout <= '0;
      for (int i = 0; i < PAGE; i++) page[i] <= 8'hFF;
      for (int r = 0; r < ROWS; r++)
        for (int i = 0; i < PAGE; i++) mem[r][i] <= 8'hFF;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
      if (done) begin
        timer <= '0;
        case (op)
          OP_RD: begin
            for (int i = 0; i < PAGE; i++) page[i] <= mem[row][i];
            mode <= M_OUT;
          end
          OP_PG: for (int i = 0; i < PAGE; i++) mem[row][i] <= page[i];
          default: for (int i = 0; i < PAGE; i++) mem[row][i] <= 8'hFF;
        endcase
      end else if (busy) begin
        timer <= timer - TW'(1);
      end

      if (cmd_stb) begin
        nab  <= '0;
        mode <= M_IDLE;
        case (io_i)
          C_RD: mode <= M_RDA;
          C_PG: begin
            mode <= M_PGA;
            for (int i = 0; i < PAGE; i++) page[i] <= 8'hFF;
          end
          C_ER: mode <= M_ERA;
          C_RDGO: if (mode == M_RDA && nab == 2'd2) begin
            timer <= TW'(T_READ); op <= OP_RD; mode <= M_RDA;
          end
          C_PGGO: if (mode == M_PGA && nab == 2'd2 && wp_n) begin
            timer <= TW'(T_PROG); op <= OP_PG;
          end
          C_ERGO: if (mode == M_ERA && nab == 2'd1 && wp_n) begin
            timer <= TW'(T_ERASE); op <= OP_ER;
          end
          default: ;
        endcase
      end

      if (adr_stb) begin
        if (mode == M_ERA && nab == 2'd0) begin
          row <= io_i[RW-1:0];
          nab <= 2'd1;
        end else if ((mode == M_RDA || mode == M_PGA) && nab < 2'd2) begin
          if (nab == 2'd0) col <= io_i[CW-1:0];
          else             row <= io_i[RW-1:0];
          nab <= nab + 2'd1;
        end
      end

      if (dat_stb && mode == M_PGA && nab == 2'd2) begin
        page[col] <= io_i;
        col <= col + CW'(1);
      end

      if (rstb) begin
        dout <= page[col];
        col  <= col + CW'(1);
      end
    end
  end

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rstb |=> col == CW'($past(col) + 1)); // R4
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull) |-> $past(cmd_stb)); // R5
  AST_WP_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull) |-> (op == OP_RD || $past(wp_n))); // R8
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(nab) && $stable(mode))); // R11
  AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stby |-> !io_oe); // R7
endmodule

// File: tb/tb_nand_front.sv
module tb_nand_front;
  localparam int PAGE = 16, ROWS = 4, T_READ = 8, T_PROG = 20, T_ERASE = 30;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1;
  logic [7:0] io_i = 0;
  logic [7:0] io_o;
  logic io_oe, busy_pull, stby;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  nand_front #(.PAGE(PAGE), .ROWS(ROWS), .T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_i(io_i), .io_o(io_o), .io_oe(io_oe),
    .busy_pull(busy_pull), .stby(stby));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    cle = c; ale = a; io_i = b; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); cle = 0; ale = 0;
  endtask

  task automatic rdb(output logic [7:0] b, output logic oe);
    re_n = 0;
    @(negedge clk); b = io_o; oe = io_oe;
    re_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (busy_pull && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic start_read(input logic [7:0] c, input logic [7:0] r, output int n);
    wr(1, 0, 8'h00); wr(0, 1, c); wr(0, 1, r); wr(1, 0, 8'h30);
    wait_ready(n);
  endtask

  typedef struct packed { logic [7:0] row, col, d0, d1; } vec_t;
  localparam vec_t VEC [4] = '{
    '{8'd0, 8'd0,  8'h11, 8'h22},
    '{8'd1, 8'd5,  8'hA5, 8'h5A},
    '{8'd2, 8'd13, 8'h3C, 8'hC3},
    '{8'd3, 8'd7,  8'h0F, 8'hF0}};

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] b; logic oe; int n;
    repeat (3) @(negedge clk);
    chk(busy_pull == 0, "R12 busy after reset", busy_pull, 0);
    chk(io_oe == 0, "R12 oe after reset", io_oe, 0);
    rst_n = 1; @(negedge clk);
    chk(stby == 1, "R7 stby with ce high", stby, 1);
    ce_n = 0; @(negedge clk);

    foreach (VEC[k]) begin
      wr(1, 0, 8'h80); wr(0, 1, VEC[k].col); wr(0, 1, VEC[k].row);
      wr(0, 0, VEC[k].d0); wr(0, 0, VEC[k].d1); wr(1, 0, 8'h10);
      wait_ready(n);
      chk(n == T_PROG, "R5 program busy width", n, T_PROG);
      start_read(VEC[k].col, VEC[k].row, n);
      chk(n == T_READ, "R5 read busy width", n, T_READ);
      rdb(b, oe);
      chk(b == VEC[k].d0 && oe, "R2 R3 R4 first byte", b, VEC[k].d0);
      rdb(b, oe);
      chk(b == VEC[k].d1, "R4 second byte", b, VEC[k].d1);
      rdb(b, oe);
      chk(b == 8'hFF, "R10 unwritten byte", b, 8'hFF);
    end

    re_n = 0; ce_n = 1; @(negedge clk);
    chk(io_oe == 0 && stby == 1, "R7 standby in output state", {io_oe, stby}, 2'b01);
    ce_n = 0; re_n = 1; @(negedge clk);
    chk(io_oe == 0, "R9 re high no drive", io_oe, 0);

    wr(1, 0, 8'h00); wr(0, 1, 8'd5); wr(0, 1, 8'd1);
    wr(0, 0, 8'h30); @(negedge clk);
    chk(busy_pull == 0, "R1 byte without cle not a command", busy_pull, 0);
    re_n = 0; @(negedge clk);
    chk(io_oe == 0, "R9 no drive outside output state", io_oe, 0);
    re_n = 1; @(negedge clk);

    wr(1, 0, 8'h00); wr(0, 1, 8'd5); wr(0, 1, 8'd1); wr(1, 0, 8'h30);
    chk(busy_pull == 1, "R1 command with cle starts read", busy_pull, 1);
    ce_n = 1; @(negedge clk);
    chk(stby == 0 && busy_pull == 1, "R6 ce high ignored while busy", {stby, busy_pull}, 2'b01);
    wait_ready(n); ce_n = 0; @(negedge clk);
    rdb(b, oe);
    chk(b == 8'hA5, "R6 read completed across ce high", b, 8'hA5);

    wp_n = 0;
    wr(1, 0, 8'h60); wr(0, 1, 8'd0); wr(1, 0, 8'hD0); @(negedge clk);
    chk(busy_pull == 0, "R8 erase blocked no busy", busy_pull, 0);
    wr(1, 0, 8'h80); wr(0, 1, 8'd0); wr(0, 1, 8'd0); wr(0, 0, 8'h77); wr(1, 0, 8'h10);
    @(negedge clk);
    chk(busy_pull == 0, "R8 program blocked no busy", busy_pull, 0);
    wp_n = 1;
    start_read(8'd0, 8'd0, n);
    rdb(b, oe);
    chk(b == 8'h11, "R8 row unchanged", b, 8'h11);

    wr(1, 0, 8'h60); wr(0, 1, 8'd2); wr(1, 0, 8'hD0);
    wait_ready(n);
    chk(n == T_ERASE, "R5 erase busy width", n, T_ERASE);
    start_read(8'd13, 8'd2, n);
    rdb(b, oe);
    chk(b == 8'hFF, "R10 erased byte", b, 8'hFF);

    ce_n = 1;
    wr(1, 0, 8'h80); wr(0, 1, 8'd7); wr(0, 1, 8'd3); wr(0, 0, 8'h99); wr(1, 0, 8'h10);
    @(negedge clk);
    chk(busy_pull == 0, "R11 no busy with ce high", busy_pull, 0);
    ce_n = 0;
    start_read(8'd7, 8'd3, n);
    rdb(b, oe);
    chk(b == 8'h0F, "R11 array untouched", b, 8'h0F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule